// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block derives a periodic interrupt tick from a 32768 Hz time base that reaches it as a single-cycle clock enable in the system clock domain. A free-running prescaler counts those enables. A 4-bit rate code chooses a power-of-two period. A tick is issued whenever the prescaler lands on a multiple of that period, so every tick sits on a period-aligned boundary of the base count.

The rate code maps to periods in a non-linear way. Code 0 turns the generator off. Codes 1 and 2 are moved up to the long periods of codes 8 and 9. Any other code c gives a period of 2^(c-1) base cycles. The generator runs only while the periodic-interrupt enable is set. A divider-hold input keeps the prescaler at zero, so the first tick after release comes one full period later. Each tick is a one-cycle flag pulse, and an interrupt-request pulse goes out with it.

Top module: `pir_rate_gen`

## Requirements
- R1: While reset is active, and in the first cycle after it, `tick_o` and `irq_o` are low.
- R2: With `rate_code_i` equal to 0, no tick and no interrupt request are ever produced.
- R3: Code 1 gives a period of 128 base enables and code 2 gives 256, the same as codes 8 and 9.
- R4: For codes 3 to 15, one tick is produced every 2^(code-1) base enables.
- R5: A tick is produced only when the prescaler count (base enables since reset or hold release, modulo 32768) becomes a multiple of the current period. After a code change, the first tick comes at the next boundary of the new period.
- R6: While `pie_i` is low, no tick and no interrupt request are produced. The prescaler keeps counting.
- R7: While `div_hold_i` is high, the prescaler is held at zero and no tick is produced. After release, the first tick comes on exactly the period-th base enable.
- R8: A tick appears on `tick_o` for exactly one system clock cycle, in the cycle after the clock edge that accepted the base enable.
- R9: `irq_o` pulses in the same cycle as `tick_o`, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| base_en_i | input | 1 | One-cycle enable at the 32768 Hz base rate |
| rate_code_i | input | 4 | Rate code (0 off, 1..2 aliased, 3..15 direct) |
| pie_i | input | 1 | Periodic interrupt enable |
| div_hold_i | input | 1 | Hold the prescaler at zero |
| tick_o | output | 1 | Periodic flag pulse |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench builds the block with its defaults: a 15-bit prescaler, a 4-bit rate code, and aliasing of codes up to 2 by seven steps. With these values every code, up to the 16384-enable period of code 15, runs for two full periods within the cycle budget. A continuous base enable makes the long periods fast to reach. A sparse enable pattern and a code change in mid-period exercise pulse placement and boundary alignment against the cycle-by-cycle model.

// File: rtl/pir_pkg.sv
package pir_pkg;
   // Default widths of the rate generator.
   localparam int unsigned PIR_RATE_W = 4;
   localparam int unsigned PIR_PRE_W  = 15;

   // Period exponent for a (non-zero) rate code, with aliasing of low codes.
   function automatic int unsigned pir_shift(input int unsigned code,
                                             input int unsigned alias_max,
                                             input int unsigned alias_add);
      int unsigned eff;
      eff = (code != 0 && code <= alias_max) ? code + alias_add : code;
      return (eff == 0) ? 0 : eff - 1;
   endfunction
endpackage

// File: rtl/pir_rate_decode.sv
module pir_rate_decode
   import pir_pkg::*;
#(
   parameter int unsigned RATE_W    = PIR_RATE_W,
   parameter int unsigned PRE_W     = PIR_PRE_W,
   parameter int unsigned ALIAS_MAX = 2,
   parameter int unsigned ALIAS_ADD = 7
) (
   input  logic [RATE_W-1:0] code_i,
   output logic              valid_o,
   output logic [PRE_W-1:0]  mask_o
);
   localparam int unsigned NCODE = 1 << RATE_W;

   logic [NCODE-1:0] code_hit;
   logic [PRE_W-1:0] code_mask [NCODE];

   // One mask per code, computed at elaboration; selected by a one-hot hit.
   for (genvar c = 0; c < NCODE; c++) begin : g_code
      localparam int unsigned SH = pir_shift(c, ALIAS_MAX, ALIAS_ADD);
      assign code_hit[c] = (code_i == RATE_W'(c));
      for (genvar b = 0; b < PRE_W; b++) begin : g_bit
         assign code_mask[c][b] = (b < SH);
      end
   end

   always_comb begin
      mask_o = '0;
      for (int c = 0; c < NCODE; c++) begin
         if (code_hit[c]) mask_o = code_mask[c];
      end
   end

   assign valid_o = (code_i != '0);
endmodule

// File: rtl/pir_prescaler.sv
module pir_prescaler #(
   parameter int unsigned PRE_W = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             base_en_i,
   input  logic             hold_i,
   output logic             step_o,
   output logic [PRE_W-1:0] next_o
);
   logic [PRE_W-1:0] cnt_q;

   assign step_o = base_en_i && !hold_i;
   assign next_o = cnt_q + PRE_W'(1);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || hold_i) begin
         cnt_q <= '0;
      end else if (base_en_i) begin
         cnt_q <= next_o;
      end
   end
endmodule

// File: rtl/pir_tick_gen.sv
module pir_tick_gen #(
   parameter int unsigned PRE_W   = 15,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             run_i,
   input  logic             pie_i,
   input  logic [PRE_W-1:0] next_i,
   input  logic [PRE_W-1:0] mask_i,
   output logic             tick_o,
   output logic             irq_o
);
   logic on_edge;
   assign on_edge = step_i && run_i && ((next_i & mask_i) == '0);

   if (OUT_REG) begin : g_reg
      logic tick_q, irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            tick_q <= 1'b0;
            irq_q  <= 1'b0;
         end else begin
            tick_q <= on_edge;
            irq_q  <= on_edge && pie_i;
         end
      end
      assign tick_o = tick_q;
      assign irq_o  = irq_q;
   end else begin : g_comb
      assign tick_o = on_edge;
      assign irq_o  = on_edge && pie_i;
   end
endmodule

// File: rtl/pir_rate_gen.sv
module pir_rate_gen
   import pir_pkg::*;
#(
   parameter int unsigned RATE_W    = PIR_RATE_W,
   parameter int unsigned PRE_W     = PIR_PRE_W,
   parameter int unsigned ALIAS_MAX = 2,
   parameter int unsigned ALIAS_ADD = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              base_en_i,
   input  logic [RATE_W-1:0] rate_code_i,
   input  logic              pie_i,
   input  logic              div_hold_i,
   output logic              tick_o,
   output logic              irq_o
);
   localparam int unsigned MAX_SHIFT = (1 << RATE_W) - 2;

   if (PRE_W <= MAX_SHIFT) begin : g_bad_pre
      $error("PRE_W must exceed the largest period exponent");
   end
   if (ALIAS_MAX + ALIAS_ADD >= (1 << RATE_W)) begin : g_bad_alias
      $error("aliased codes must stay inside the code range");
   end

   logic             code_ok, step;
   logic [PRE_W-1:0] mask, cnt_next;

   pir_rate_decode #(
      .RATE_W(RATE_W), .PRE_W(PRE_W),
      .ALIAS_MAX(ALIAS_MAX), .ALIAS_ADD(ALIAS_ADD)
   ) i_dec (
      .code_i (rate_code_i),
      .valid_o(code_ok),
      .mask_o (mask)
   );

   pir_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .base_en_i(base_en_i),
      .hold_i   (div_hold_i),
      .step_o   (step),
      .next_o   (cnt_next)
   );

   pir_tick_gen #(.PRE_W(PRE_W), .OUT_REG(1'b1)) i_tick (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(step),
      .run_i (code_ok && pie_i),
      .pie_i (pie_i),
      .next_i(cnt_next),
      .mask_i(mask),
      .tick_o(tick_o),
      .irq_o (irq_o)
   );
endmodule

// File: rtl/pir_rate_gen_chk.sv
module pir_rate_gen_chk #(
   parameter int unsigned RATE_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              base_en_i,
   input logic [RATE_W-1:0] rate_code_i,
   input logic              pie_i,
   input logic              div_hold_i,
   input logic              tick_o,
   input logic              irq_o
);
   // R8
   tick_after_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> $past(base_en_i));
   // R8
   tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
   // R6
   tick_needs_pie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> $past(pie_i));
   // R2
   tick_needs_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> ($past(rate_code_i) != '0));
   // R7
   hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(div_hold_i) |-> !tick_o);
   // R9
   irq_with_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> tick_o);
endmodule

bind pir_rate_gen pir_rate_gen_chk #(.RATE_W(RATE_W)) i_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .base_en_i(base_en_i),
   .rate_code_i(rate_code_i), .pie_i(pie_i), .div_hold_i(div_hold_i),
   .tick_o(tick_o), .irq_o(irq_o)
);

// File: tb/test_pir_rate_gen.sv
module test_pir_rate_gen;
   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       base_en_i = 1'b0;
   logic [3:0] rate_code_i = 4'd0;
   logic       pie_i = 1'b0;
   logic       div_hold_i = 1'b0;
   logic       tick_o, irq_o;

   int checks = 0, failures = 0, nticks = 0, ncyc = 0;
   int model_cnt = 0;
   bit exp_tick = 1'b0;
   string cur_req = "R1";

   always #5 clk_i = ~clk_i;

   pir_rate_gen i_pir_rate_gen (.*);

   function automatic int period_of(input int code);
      int c;
      c = (code == 1 || code == 2) ? code + 7 : code;
      return 1 << (c - 1);
   endfunction

   // Behavioural reference, advanced on every clock edge.
   always @(posedge clk_i) begin
      ncyc++;
      if (!rst_ni || div_hold_i) begin
         model_cnt = 0;
         exp_tick  = 1'b0;
      end else if (base_en_i) begin
         model_cnt = (model_cnt + 1) % 32768;
         exp_tick  = pie_i && rate_code_i != 0 &&
                     (model_cnt % period_of(rate_code_i)) == 0;
      end else begin
         exp_tick = 1'b0;
      end
   end

   always @(negedge clk_i) begin
      checks++;
      if (tick_o !== exp_tick || irq_o !== exp_tick) begin
         failures++;
         $display("FAIL %s tick_o=%0b irq_o=%0b expected %0b (R9 for irq)",
                  cur_req, tick_o, irq_o, exp_tick);
      end
      if (tick_o === 1'b1) nticks++;
   end

   task automatic cyc(input logic en);
      base_en_i = en;
      @(negedge clk_i);
      #1;
   endtask

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic hold_and_set(input int code);
      div_hold_i = 1'b1;
      cyc(1'b1);
      cyc(1'b0);
      rate_code_i = 4'(code);
      div_hold_i  = 1'b0;
   endtask

   initial begin
      int t0, first;
      #1;
      // R1 reset state
      cyc(1'b1); cyc(1'b1);
      check("R1 tick during reset", tick_o, 0);
      check("R1 irq during reset", irq_o, 0);
      rst_ni = 1'b1;
      cyc(1'b1);
      check("R1 tick after reset", tick_o, 0);

      // R2 code 0 never ticks
      cur_req = "R2"; pie_i = 1'b1; rate_code_i = 4'd0;
      t0 = nticks;
      for (int i = 0; i < 300; i++) cyc(1'b1);
      check("R2 ticks with code 0", nticks - t0, 0);

      // R6 pie low stops ticks
      cur_req = "R6"; pie_i = 1'b0; rate_code_i = 4'd3;
      t0 = nticks;
      for (int i = 0; i < 100; i++) cyc(1'b1);
      check("R6 ticks with pie low", nticks - t0, 0);
      pie_i = 1'b1;

      // R7 first tick after release on the period-th enable
      cur_req = "R7";
      hold_and_set(3);
      first = 0;
      for (int i = 1; i <= 8 && first == 0; i++) begin
         t0 = nticks;
         cyc(1'b1);
         if (nticks != t0) first = i;
      end
      check("R7 enables to first tick", first, 4);

      // R3 / R4 every code, two periods each
      for (int c = 1; c < 16; c++) begin
         cur_req = (c <= 2) ? "R3" : "R4";
         hold_and_set(c);
         t0 = nticks;
         for (int i = 0; i < 2 * period_of(c); i++) cyc(1'b1);
         check((c <= 2) ? "R3 ticks in two periods" : "R4 ticks in two periods",
               nticks - t0, 2);
      end

      // R5 code change mid-period aligns to the new period
      cur_req = "R5";
      hold_and_set(5);
      for (int i = 0; i < 10; i++) cyc(1'b1);
      rate_code_i = 4'd3;
      t0 = nticks;
      cyc(1'b1);
      check("R5 no tick at count 11", nticks - t0, 0);
      cyc(1'b1);
      check("R5 tick at count 12", nticks - t0, 1);

      // R8 sparse base enable
      cur_req = "R8";
      hold_and_set(3);
      t0 = nticks;
      for (int i = 0; i < 24; i++) cyc(i % 3 == 0);
      check("R8 ticks with sparse enable", nticks - t0, 2);
      cyc(1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (ncyc >= 190000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", ncyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule